// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer attached to a simple 32-bit register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. A free-running timebase counter advances on every clock, and software can read it back. A separate interval counter runs while the watchdog is enabled. The interval is 2^`INTERVAL_LOG2` clocks.

Expiry happens in two stages. When the first interval elapses, the block raises a warning flag and a level interrupt. If software does not service the watchdog before the next interval elapses, the block pulses a reset output for `PULSE_LEN` clocks and latches a reset-status flag. Software services the watchdog by writing ones over the flags it wants cleared; any such write also restarts the interval count.

Two enable bits sit in different registers. The watchdog runs while either bit is set. A build-time option turns both bits into set-only bits, so that once the watchdog has started it cannot be stopped until system reset.

Top module: `wdog_top`

## Requirements
- R1: After reset, `wd_irq` and `wd_rst_out` are low, and the registers at offsets 0x0 and 0x4 read zero.
- R2: Register layout and read behaviour:
  - Offset 0x0 reads reset-status at bit 3, the warning flag at bit 2 and enable A at bit 1.
  - Offset 0x4 reads enable B at bit 0.
  - Offset 0x8 reads the timebase.
  - All other bits read zero, any other offset reads zero, and `bus_rdata` is zero whenever `bus_re` is low.
- R3: The timebase increases by one on every clock once reset has been released. Writes to offset 0x8 have no effect on it.
- R4: The interval count advances only while enable A (bit 1 at 0x0) or enable B (bit 0 at 0x4) is set. With both bits clear the count is held at zero and no expiry occurs.
- R5: The first expiry occurs 2^`INTERVAL_LOG2` enabled clocks after the count starts from zero. It sets the warning flag, and `wd_irq` is high exactly while that flag is set.
- R6: An expiry that occurs while the warning flag is already set has these effects:
  - It sets reset-status.
  - It drives `wd_rst_out` high for exactly `PULSE_LEN` clocks.
  - It leaves the warning flag set.
- R7: A write to 0x0 with bit 3 and/or bit 2 set clears the matching flag(s) and restarts the interval count from zero. A write with zeros in those bits leaves the flags unchanged.
- R8: A restart write that lands in the same clock as an interval overflow takes priority: that overflow produces no expiry, and the next expiry comes one full interval later.
- R9: With `ENABLE_ONCE` set, writes cannot clear an enable bit once it is set. The watchdog keeps running until system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one access per clock |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid in the same clock as `bus_re` |
| wd_irq | output | 1 | Warning interrupt level |
| wd_rst_out | output | 1 | Reset request pulse |

## Verification
The hazard is a service write that falls in the very clock in which the interval count reaches its last value. In that clock, a restart and an expiry compete for the same flags. The bench counts clocks from a known restart so that a service write lands exactly on that overflow clock. It then expects the interrupt to stay low for the whole next interval and to rise only one full interval later. A behavioural reference model judges every clock, and it also judges a stretch of random traffic in which service writes, enable changes and overflows collide at random.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register offsets; software depends on these
  localparam logic [3:0] OFF_CTRL_A = 4'h0;
  localparam logic [3:0] OFF_CTRL_B = 4'h4;
  localparam logic [3:0] OFF_TBASE  = 4'h8;

  // bit positions inside the control registers
  localparam int B_RSTSTAT = 3;
  localparam int B_WARN    = 2;
  localparam int B_EN_A    = 1;
  localparam int B_EN_B    = 0;

  typedef enum logic {ST_QUIET = 1'b0, ST_WARNED = 1'b1} warn_state_e;

  typedef struct packed {
    logic run;
    logic kick;
    logic clr_warn;
    logic clr_rst;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] val_q, val_d;

  always_comb val_d = val_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic              warn_flag,
  input  logic              rst_flag,
  input  logic [DATA_W-1:0] tbase,
  output wd_ctrl_t          ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL_A = ADDR_W'(OFF_CTRL_A);
  localparam logic [ADDR_W-1:0] A_CTRL_B = ADDR_W'(OFF_CTRL_B);
  localparam logic [ADDR_W-1:0] A_TBASE  = ADDR_W'(OFF_TBASE);

  logic sel_a, sel_b, sel_t, wr_a, wr_b;
  logic en_a_q, en_a_d, en_b_q, en_b_d;
  logic unused_wdata_hi;

  assign sel_a = (addr == A_CTRL_A);
  assign sel_b = (addr == A_CTRL_B);
  assign sel_t = (addr == A_TBASE);
  assign wr_a  = we & sel_a;
  assign wr_b  = we & sel_b;
  assign unused_wdata_hi = ^wdata[DATA_W-1:4];

  generate
    if (ENABLE_ONCE) begin : g_set_only
      always_comb begin
        en_a_d = en_a_q | wdata[B_EN_A];
        en_b_d = en_b_q | wdata[B_EN_B];
      end
    end else begin : g_free
      always_comb begin
        en_a_d = wdata[B_EN_A];
        en_b_d = wdata[B_EN_B];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_a_q <= 1'b0;
    else if (wr_a) en_a_q <= en_a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_b_q <= 1'b0;
    else if (wr_b) en_b_q <= en_b_d;
  end

  always_comb begin
    ctrl.run      = en_a_q | en_b_q;
    ctrl.kick     = wr_a & (wdata[B_RSTSTAT] | wdata[B_WARN]);
    ctrl.clr_warn = wr_a & wdata[B_WARN];
    ctrl.clr_rst  = wr_a & wdata[B_RSTSTAT];
  end

  always_comb begin
    rdata = '0;
    if (re) begin
      if (sel_a) begin
        rdata[B_RSTSTAT] = rst_flag;
        rdata[B_WARN]    = warn_flag;
        rdata[B_EN_A]    = en_a_q;
      end else if (sel_b) begin
        rdata[B_EN_B] = en_b_q;
      end else if (sel_t) begin
        rdata = tbase;
      end
    end
  end
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry
  import wdog_pkg::*;
#(
  parameter int INTERVAL_LOG2 = 20,
  parameter int PULSE_LEN     = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  wd_ctrl_t ctrl,
  output logic     warn_flag,
  output logic     rst_flag,
  output logic     rst_pulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [INTERVAL_LOG2-1:0] CNT_LAST = '1;

  logic [INTERVAL_LOG2-1:0] cnt_q, cnt_d;
  logic                     cnt_en, ovf;
  warn_state_e              st_q, st_d;
  logic                     rst_q, rst_d;
  logic [PW-1:0]            pc_q, pc_d;

  // interval counter: held at zero when stopped, restarted by a service write
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q + INTERVAL_LOG2'(1);
    if (!ctrl.run || ctrl.kick) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end
  end

  // a service write in the overflow clock wins over the expiry
  assign ovf = ctrl.run & ~ctrl.kick & (cnt_q == CNT_LAST);

  always_comb begin
    st_d  = ctrl.clr_warn ? ST_QUIET : st_q;
    rst_d = rst_q & ~ctrl.clr_rst;
    pc_d  = (pc_q != '0) ? pc_q - PW'(1) : '0;
    if (ovf) begin
      if (st_q == ST_QUIET) begin
        st_d = ST_WARNED;
      end else begin
        rst_d = 1'b1;
        pc_d  = PW'(PULSE_LEN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_QUIET;
      rst_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      rst_q <= rst_d;
      pc_q  <= pc_d;
    end
  end

  assign warn_flag = (st_q == ST_WARNED);
  assign rst_flag  = rst_q;
  assign rst_pulse = (pc_q != '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int INTERVAL_LOG2 = 20,
  parameter int PULSE_LEN     = 4,
  parameter bit ENABLE_ONCE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_rst_out
);
  logic              rst_int_n;
  logic [DATA_W-1:0] tbase_val;
  wd_ctrl_t          ctrl;
  logic              warn_flag, rst_flag;

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  wdog_timebase #(.W(DATA_W)) u_timebase (
    .clk(clk), .rst_n(rst_int_n), .value(tbase_val)
  );

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENABLE_ONCE(ENABLE_ONCE)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .warn_flag(warn_flag), .rst_flag(rst_flag),
    .tbase(tbase_val), .ctrl(ctrl), .rdata(bus_rdata)
  );

  wdog_expiry #(
    .INTERVAL_LOG2(INTERVAL_LOG2), .PULSE_LEN(PULSE_LEN)
  ) u_expiry (
    .clk(clk), .rst_n(rst_int_n), .ctrl(ctrl), .warn_flag(warn_flag),
    .rst_flag(rst_flag), .rst_pulse(wd_rst_out)
  );

  assign wd_irq = warn_flag;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int PULSE_LEN   = 4,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic              re,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              rst_out,
  input logic              run,
  input logic [DATA_W-1:0] tbase
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  localparam logic [ADDR_W-1:0] A_A = ADDR_W'(OFF_CTRL_A);
  localparam logic [ADDR_W-1:0] A_B = ADDR_W'(OFF_CTRL_B);
  localparam logic [ADDR_W-1:0] A_T = ADDR_W'(OFF_TBASE);

  logic          past_ok;
  logic [HW-1:0] hi_len;
  logic          svc;

  assign svc = we && (addr == A_A) && (wdata[B_RSTSTAT] || wdata[B_WARN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hi_len <= '0;
    else if (!rst_out)                      hi_len <= '0;
    else if (hi_len != HW'(PULSE_LEN + 1))  hi_len <= hi_len + HW'(1);
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!re || (addr != A_A && addr != A_B && addr != A_T)) |-> rdata == '0); // R2
  AST_TBASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> tbase == $past(tbase) + DATA_W'(1)); // R3
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !irq) |=> !irq); // R4
  AST_RESET_AFTER_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> irq); // R6
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> hi_len < HW'(PULSE_LEN)); // R6
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(rst_out)) |-> hi_len == HW'(PULSE_LEN)); // R6
  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_A && wdata[B_WARN]) |=> !irq); // R7
  AST_SERVICE_BEATS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && !irq) |=> !irq); // R8
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE_ONCE && past_ok && $past(run)) |-> run); // R9
endmodule

bind wdog_top wdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN), .ENABLE_ONCE(ENABLE_ONCE)
) u_wdog_chk (
  .clk(clk), .rst_n(rst_int_n), .we(bus_we), .re(bus_re), .addr(bus_addr),
  .wdata(bus_wdata), .rdata(bus_rdata), .irq(wd_irq), .rst_out(wd_rst_out),
  .run(ctrl.run), .tbase(tbase_val)
);

// File: tb/tb_wdog_ref.sv
module tb_wdog_ref #(
  parameter int N     = 4,
  parameter bit ONCE  = 1'b0,
  parameter int PULSE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        re,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic        e_irq,
  output logic        e_rst,
  output logic [31:0] e_rdata
);
  int          age, cnt, pulse_left;
  bit          en1, en2, wds, wrs;
  logic [31:0] tb;
  bit          running, svc, expire;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age = 0; cnt = 0; pulse_left = 0;
      en1 = 0; en2 = 0; wds = 0; wrs = 0; tb = 0;
    end else if (age < 2) begin
      age = age + 1;
    end else begin
      running = en1 || en2;
      svc     = we && addr == 4'h0 && (wdata[3] || wdata[2]);
      expire  = running && !svc && cnt == (1 << N) - 1;
      cnt     = (!running || svc) ? 0 : (cnt + 1) % (1 << N);
      if (pulse_left > 0) pulse_left = pulse_left - 1;
      if (we && addr == 4'h0) begin
        if (wdata[3]) wrs = 0;
        if (wdata[2]) wds = 0;
        en1 = ONCE ? (en1 | wdata[1]) : wdata[1];
      end
      if (we && addr == 4'h4) en2 = ONCE ? (en2 | wdata[0]) : wdata[0];
      if (expire) begin
        if (!wds) wds = 1;
        else begin wrs = 1; pulse_left = PULSE; end
      end
      tb = tb + 1;
    end
  end

  assign e_irq   = wds;
  assign e_rst   = pulse_left > 0;
  assign e_rdata = !re ? 32'd0 :
                   addr == 4'h0 ? {28'd0, wrs, wds, en1, 1'b0} :
                   addr == 4'h4 ? {31'd0, en2} :
                   addr == 4'h8 ? tb : 32'd0;
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rd0, rd1, e_rd0, e_rd1, rd_a, rd_b, t1, t2, t3;
  logic        irq0, irq1, ro0, ro1, e_irq0, e_irq1, e_ro0, e_ro1;
  int          checks = 0, errs = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_top #(.ADDR_W(4), .DATA_W(32), .INTERVAL_LOG2(N), .PULSE_LEN(PULSE), .ENABLE_ONCE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_re(re), .bus_rdata(rd0), .wd_irq(irq0), .wd_rst_out(ro0));
  wdog_top #(.ADDR_W(4), .DATA_W(32), .INTERVAL_LOG2(N), .PULSE_LEN(PULSE), .ENABLE_ONCE(1'b1)) dut_lock (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_re(re), .bus_rdata(rd1), .wd_irq(irq1), .wd_rst_out(ro1));

  tb_wdog_ref #(.N(N), .ONCE(1'b0), .PULSE(PULSE)) ref0 (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .e_irq(e_irq0), .e_rst(e_ro0), .e_rdata(e_rd0));
  tb_wdog_ref #(.N(N), .ONCE(1'b1), .PULSE(PULSE)) ref1 (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .e_irq(e_irq1), .e_rst(e_ro1), .e_rdata(e_rd1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  endtask

  // one bus clock: drive at the falling edge, sample read data, pass one rising edge
  task automatic bus(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d);
    we = w; re = r; addr = a; wdata = d;
    #1;
    rd_a = rd0; rd_b = rd1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clock-by-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      chk("R5 irq vs model", {31'd0, irq0}, {31'd0, e_irq0});
      chk("R6 rst_out vs model", {31'd0, ro0}, {31'd0, e_ro0});
      chk("R2 rdata vs model", rd0, e_rd0);
      chk("R9 lock irq vs model", {31'd0, irq1}, {31'd0, e_irq1});
      chk("R9 lock rst_out vs model", {31'd0, ro1}, {31'd0, e_ro1});
      chk("R9 lock rdata vs model", rd1, e_rd1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL run limit reached actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 irq", {31'd0, irq0}, 32'd0);
    chk("R1 rst_out", {31'd0, ro0}, 32'd0);
    bus(0, 1, 4'h0, 0); chk("R1 ctrl A", rd_a, 32'd0);
    bus(0, 1, 4'h4, 0); chk("R1 ctrl B", rd_a, 32'd0);
    // R2 unmapped offset
    bus(0, 1, 4'hC, 0); chk("R2 unmapped", rd_a, 32'd0);
    // R3 timebase
    bus(0, 1, 4'h8, 0); t1 = rd_a;
    bus(0, 1, 4'h8, 0); t2 = rd_a;
    chk("R3 timebase step", t2, t1 + 1);
    bus(1, 0, 4'h8, 32'hFFFF_FFFF);
    bus(0, 1, 4'h8, 0); t3 = rd_a;
    chk("R3 timebase write ignored", t3, t2 + 2);
    // R5 first expiry with enable A only
    bus(1, 0, 4'h0, 32'h2);
    idle(15); chk("R5 before first overflow", {31'd0, irq0}, 32'd0);
    idle(1);  chk("R5 first overflow irq", {31'd0, irq0}, 32'd1);
    chk("R6 no reset at first overflow", {31'd0, ro0}, 32'd0);
    // R7 zero write keeps flags
    bus(1, 0, 4'h0, 32'h2);
    bus(0, 1, 4'h0, 0); chk("R7 zero write keeps flag", rd_a, 32'h6);
    // R6 second expiry
    idle(13); chk("R6 before second overflow", {31'd0, ro0}, 32'd0);
    idle(1);  chk("R6 reset pulse start", {31'd0, ro0}, 32'd1);
    idle(3);  chk("R6 reset pulse last clock", {31'd0, ro0}, 32'd1);
    idle(1);  chk("R6 reset pulse end", {31'd0, ro0}, 32'd0);
    bus(0, 1, 4'h0, 0); chk("R6 status flags", rd_a, 32'hE);
    // R7 service clears both flags
    bus(1, 0, 4'h0, 32'hE);
    bus(0, 1, 4'h0, 0); chk("R7 flags cleared", rd_a, 32'h2);
    chk("R7 irq low", {31'd0, irq0}, 32'd0);
    // R8 service on the overflow clock
    idle(14);
    bus(1, 0, 4'h0, 32'h6);
    chk("R8 no expiry on collision", {31'd0, irq0}, 32'd0);
    idle(15); chk("R8 still quiet", {31'd0, irq0}, 32'd0);
    idle(1);  chk("R8 expiry one interval later", {31'd0, irq0}, 32'd1);
    // R4 stop, R9 lock
    bus(1, 0, 4'h0, 32'hC);
    bus(0, 1, 4'h0, 0);
    chk("R4 stopped reads zero", rd_a, 32'd0);
    chk("R9 enable kept under lock", rd_b, 32'h2);
    idle(40);
    chk("R4 no expiry while stopped", {31'd0, irq0}, 32'd0);
    chk("R9 locked instance still expires", {31'd0, irq1}, 32'd1);
    // R4 enable B alone
    bus(1, 0, 4'h4, 32'h1);
    idle(15); chk("R4 enable B before overflow", {31'd0, irq0}, 32'd0);
    idle(1);  chk("R4 enable B expiry", {31'd0, irq0}, 32'd1);
    bus(0, 1, 4'h4, 0); chk("R2 ctrl B bit0", rd_a, 32'd1);
    // random traffic judged by the model
    for (int i = 0; i < 400; i++) begin
      bus($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
          {2'(($urandom_range(0, 3))), 2'b00}, $urandom);
    end
    idle(2);
    finish_run();
  end
endmodule